// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block follows a linked list of frame descriptors stored in word-addressed memory and converts each descriptor into a series of fragment transfer requests. Each descriptor has a fixed layout. Word 0 holds the link to the next descriptor. Word 1 holds the control and status half in bits 15:0 and the frame size in bits 31:16. From word 2 onward come pairs of words: a fragment byte count, then a fragment address. When the last fragment of a frame has been accepted, the walker writes word 1 back with the completion flag set. It then moves to the linked descriptor, or stops.

Software builds a chain in memory, marks each descriptor ready, and pulses `start` with the head address. The walker reads through the chain one word at a time over a read request/valid port. It offers each fragment on a request/acknowledge port, and sends each status update as a single-cycle write. A frame that totals fewer than the minimum length gets one extra padding request. A single-fragment mode shrinks every descriptor to four words. A stop request takes effect only between descriptors.

The controller moves through the following states:
- ST_IDLE: waits for `start`, then goes to ST_LINK.
- ST_LINK: reads the link word, then goes to ST_STAT.
- ST_STAT: reads the status word. It goes to ST_CNT if the descriptor is ready, or back to ST_IDLE with a chain-end event if not.
- ST_CNT: reads the fragment count word, then goes to ST_ADR.
- ST_ADR: reads the fragment address word, then goes to ST_ISSUE.
- ST_ISSUE: offers the fragment. On acknowledge it goes to ST_CNT for the next fragment. After the final fragment it goes to ST_PAD if the frame is short, or to ST_WBACK otherwise.
- ST_PAD: offers the padding request. On acknowledge it goes to ST_WBACK.
- ST_WBACK: writes the status back. It goes to ST_LINK to follow the chain, or to ST_IDLE when the chain ends or a stop is pending.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the block is idle: `rd_req`, `wr_en`, `frag_req`, `frame_done` and `chain_end` are all low, and no memory access happens until `start`.
- R2: On `start` in idle, the block reads the link word at the head address, then the status word at head+1. A read request holds its address steady until `rd_valid`.
- R3: Each fragment is offered in list order. `frag_addr` carries the address word, and `frag_len` carries bits 15:0 of the count word. The request holds steady until `frag_ack`.
- R4: Bit 31 of a count word marks the final fragment, and no further pairs are read after it. If no count word has bit 31 set, the list ends after MAX_FRAGS fragments.
- R5: When `single_frag` is high at `start`, every descriptor in that run holds exactly one fragment pair, at words 2 and 3, whatever the value of its bit 31.
- R6: After a frame, the block writes word 1 of the descriptor back with status bit 14 (frame complete) set and all other bits unchanged. `frame_done` pulses in the same cycle.
- R7: After the write-back, a non-zero link is followed to the next descriptor. A zero link pulses `chain_end` and returns the block to idle.
- R8: A descriptor whose status bits 13:12 are not both 1 is not processed. It produces no fragment and no write, and `chain_end` pulses.
- R9: A processed descriptor with status bit 11 set ends the chain after its write-back: `chain_end` pulses and the link is not followed.
- R10: If a frame's fragment lengths add up to less than MIN_FRAME bytes, one extra request with `frag_pad` high, address 0 and length MIN_FRAME minus the sum is offered before the write-back.
- R11: A `stop` while busy lets the current frame finish and be written back. The block then goes idle without reading the next descriptor and without pulsing `chain_end`.
- R12: A `start` that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking at `head_addr` (idle only) |
| head_addr | input | AW | Word address of the first descriptor |
| stop | input | 1 | Halt at the next descriptor boundary |
| single_frag | input | 1 | One fragment pair per descriptor, sampled at start |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read word address |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Status write-back strobe |
| wr_addr | output | AW | Write-back word address |
| wr_data | output | 32 | Write-back data |
| frag_req | output | 1 | Fragment transfer request |
| frag_addr | output | 32 | Fragment buffer address (0 for padding) |
| frag_len | output | LEN_W | Fragment byte count |
| frag_pad | output | 1 | Request is minimum-length padding |
| frag_ack | input | 1 | Fragment request accepted |
| frame_done | output | 1 | One-cycle pulse at each write-back |
| chain_end | output | 1 | One-cycle pulse when the chain ends |

## Verification
The hold assertions take for granted that memory answers a read only while `rd_req` is high, and that the transfer side raises `frag_ack` only while `frag_req` is high. The write-back assertion takes for granted that nothing but this block changes a descriptor between its status read and its write-back. The bench's memory and transfer models answer each request exactly once, one cycle after seeing it, and keep every descriptor untouched while a walk runs. The bench drives `start` and `stop` only between clock edges, and rebuilds each test's descriptors only while the block is idle.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINK,
        ST_STAT,
        ST_CNT,
        ST_ADR,
        ST_ISSUE,
        ST_PAD,
        ST_WBACK
    } walk_state_e;

    localparam int RDY_HI_BIT = 13;
    localparam int RDY_LO_BIT = 12;
    localparam int CMPL_BIT   = 14;
    localparam int EOC_BIT    = 11;
    localparam int LAST_BIT   = 31;
endpackage

// File: rtl/dwalk_addr_gen.sv
module dwalk_addr_gen
    import dwalk_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 4
) (
    input  walk_state_e      st,
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] pair_off;

    assign pair_off = AW'(idx) << 1;

    always_comb begin
        case (st)
            ST_STAT, ST_WBACK: addr = base + AW'(1);
            ST_CNT:            addr = base + AW'(2) + pair_off;
            ST_ADR:            addr = base + AW'(3) + pair_off;
            default:           addr = base;
        endcase
    end
endmodule

// File: rtl/dwalk_len_acc.sv
module dwalk_len_acc #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAGS = 10,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    output logic             short_after,
    output logic [LEN_W-1:0] pad_len
);
    localparam int SUM_W = LEN_W + $clog2(MAX_FRAGS + 1);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_plus;

    assign sum_plus    = sum_q + SUM_W'(add_len);
    assign short_after = sum_plus < SUM_W'(MIN_FRAME);
    assign pad_len     = LEN_W'(SUM_W'(MIN_FRAME) - sum_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum_q <= '0;
        else if (clr)    sum_q <= '0;
        else if (add_en) sum_q <= sum_plus;
    end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dwalk_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LEN_W     = 16,
    parameter int MAX_FRAGS = 10,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    head_addr,
    input  logic             stop,
    input  logic             single_frag,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_valid,
    input  logic [31:0]      rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic             frag_req,
    output logic [31:0]      frag_addr,
    output logic [LEN_W-1:0] frag_len,
    output logic             frag_pad,
    input  logic             frag_ack,
    output logic             frame_done,
    output logic             chain_end
);
    localparam int IDX_W = $clog2(MAX_FRAGS + 1);

    walk_state_e      state_q, state_d;
    logic [AW-1:0]    base_q;
    logic [31:0]      link_q;
    logic [31:0]      stat_q;
    logic             last_q;
    logic [LEN_W-1:0] len_q;
    logic [31:0]      fadr_q;
    logic [IDX_W-1:0] idx_q;
    logic             one_q;
    logic             stop_q;
    logic [AW-1:0]    gen_addr;
    logic             short_after;
    logic [LEN_W-1:0] pad_len;
    logic             frag_final;
    logic             desc_ready;
    logic             chain_over;

    assign desc_ready = rd_data[RDY_HI_BIT] & rd_data[RDY_LO_BIT];
    assign frag_final = one_q | last_q | (idx_q == IDX_W'(MAX_FRAGS - 1));
    assign chain_over = (link_q == 32'd0) | stat_q[EOC_BIT];

    dwalk_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
        .st   (state_q),
        .base (base_q),
        .idx  (idx_q),
        .addr (gen_addr)
    );

    dwalk_len_acc #(.LEN_W(LEN_W), .MAX_FRAGS(MAX_FRAGS), .MIN_FRAME(MIN_FRAME)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (state_q == ST_STAT && rd_valid),
        .add_en      (state_q == ST_ISSUE && frag_ack),
        .add_len     (len_q),
        .short_after (short_after),
        .pad_len     (pad_len)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LINK;
            ST_LINK:  if (rd_valid) state_d = ST_STAT;
            ST_STAT:  if (rd_valid) state_d = desc_ready ? ST_CNT : ST_IDLE;
            ST_CNT:   if (rd_valid) state_d = ST_ADR;
            ST_ADR:   if (rd_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (frag_ack) begin
                if (!frag_final)     state_d = ST_CNT;
                else if (short_after) state_d = ST_PAD;
                else                 state_d = ST_WBACK;
            end
            ST_PAD:   if (frag_ack) state_d = ST_WBACK;
            ST_WBACK: state_d = (chain_over || stop_q) ? ST_IDLE : ST_LINK;
        endcase
    end

    // descriptor fields and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            link_q <= '0;
            stat_q <= '0;
            last_q <= 1'b0;
            len_q  <= '0;
            fadr_q <= '0;
            idx_q  <= '0;
            one_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (start) begin
                    base_q <= head_addr;
                    one_q  <= single_frag;
                    stop_q <= 1'b0;
                end
            end else if (stop) begin
                stop_q <= 1'b1;
            end
            if (state_q == ST_LINK && rd_valid) link_q <= rd_data;
            if (state_q == ST_STAT && rd_valid) begin
                stat_q <= rd_data;
                idx_q  <= '0;
            end
            if (state_q == ST_CNT && rd_valid) begin
                last_q <= rd_data[LAST_BIT];
                len_q  <= rd_data[LEN_W-1:0];
            end
            if (state_q == ST_ADR && rd_valid) fadr_q <= rd_data;
            if (state_q == ST_ISSUE && frag_ack && !frag_final) idx_q <= idx_q + IDX_W'(1);
            if (state_q == ST_WBACK && !chain_over && !stop_q) base_q <= link_q[AW-1:0];
        end
    end

    // outputs
    always_comb begin
        rd_req     = 1'b0;
        rd_addr    = gen_addr;
        wr_en      = 1'b0;
        wr_addr    = gen_addr;
        wr_data    = {stat_q[31:16], stat_q[15:0] | 16'(1 << CMPL_BIT)};
        frag_req   = 1'b0;
        frag_addr  = fadr_q;
        frag_len   = len_q;
        frag_pad   = 1'b0;
        frame_done = 1'b0;
        chain_end  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LINK, ST_CNT, ST_ADR: rd_req = 1'b1;
            ST_STAT: begin
                rd_req    = 1'b1;
                chain_end = rd_valid & ~desc_ready;
            end
            ST_ISSUE: frag_req = 1'b1;
            ST_PAD: begin
                frag_req  = 1'b1;
                frag_pad  = 1'b1;
                frag_addr = '0;
                frag_len  = pad_len;
            end
            ST_WBACK: begin
                wr_en      = 1'b1;
                frame_done = 1'b1;
                chain_end  = chain_over;
            end
        endcase
    end

    a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_en, frag_req}));

    a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    a_r3_frag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frag_req && !frag_ack |=> frag_req && $stable(frag_addr) && $stable(frag_len) && $stable(frag_pad));

    a_r6_wback_flags: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data[CMPL_BIT] && wr_data[RDY_HI_BIT] && wr_data[RDY_LO_BIT] && frame_done);

    a_r10_pad_len: assert property (@(posedge clk) disable iff (!rst_n)
        frag_req && frag_pad |-> frag_len != '0 && frag_len <= LEN_W'(MIN_FRAME));

    a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |=> !rd_req && !frag_req && !wr_en);
endmodule

// File: tb/tb_desc_chain_walker.sv
module tb_desc_chain_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] head_addr = '0;
    logic        stop = 1'b0;
    logic        single_frag = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        frag_req;
    logic [31:0] frag_addr;
    logic [15:0] frag_len;
    logic        frag_pad;
    logic        frag_ack = 1'b0;
    logic        frame_done;
    logic        chain_end;

    logic [31:0] mem [0:1023];
    logic [31:0] lg_addr [0:31];
    logic [15:0] lg_len [0:31];
    logic        lg_pad [0:31];
    int nfr = 0, nwr = 0, ndone = 0, neoc = 0, nrd = 0;
    int total = 0, fails = 0;

    always #10 clk = ~clk;

    desc_chain_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .stop(stop), .single_frag(single_frag),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frag_req(frag_req), .frag_addr(frag_addr), .frag_len(frag_len),
        .frag_pad(frag_pad), .frag_ack(frag_ack),
        .frame_done(frame_done), .chain_end(chain_end)
    );

    // memory and transfer models: answer one cycle after a request
    always @(posedge clk) begin
        if (rd_req && !rd_valid) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[rd_addr[9:0]];
            nrd      <= nrd + 1;
        end else begin
            rd_valid <= 1'b0;
        end
        if (frag_req && !frag_ack) frag_ack <= 1'b1;
        else                       frag_ack <= 1'b0;
        if (frag_req && frag_ack && nfr < 32) begin
            lg_addr[nfr] <= frag_addr;
            lg_len[nfr]  <= frag_len;
            lg_pad[nfr]  <= frag_pad;
            nfr <= nfr + 1;
        end
        if (wr_en) begin
            mem[wr_addr[9:0]] <= wr_data;
            nwr <= nwr + 1;
        end
        if (frame_done) ndone <= ndone + 1;
        if (chain_end)  neoc  <= neoc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk);
        nfr = 0; nwr = 0; ndone = 0; neoc = 0; nrd = 0;
    endtask

    task automatic kick(input logic [15:0] head, input logic one);
        @(negedge clk);
        start = 1'b1; head_addr = head; single_frag = one;
        @(negedge clk);
        start = 1'b0; single_frag = 1'b0;
    endtask

    task automatic settle();
        repeat (300) @(negedge clk);
    endtask

    task automatic chk_frag(input string req, input int i, input logic [31:0] a,
                            input logic [15:0] l, input logic p);
        chk(req, lg_addr[i], a);
        chk(req, 32'(lg_len[i]), 32'(l));
        chk(req, 32'(lg_pad[i]), 32'(p));
    endtask

    task automatic t_reset();
        repeat (20) @(negedge clk);
        chk("R1 rd_req", 32'(rd_req), 0);
        chk("R1 frag_req", 32'(frag_req), 0);
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 events", 32'({frame_done, chain_end}), 0);
        chk("R1 no reads", nrd, 0);
    endtask

    task automatic t_chain();
        clear_logs();
        mem[10'h100] = 32'h200; mem[10'h101] = 32'h0064_3000;
        mem[10'h102] = 32'd40;  mem[10'h103] = 32'h1000;
        mem[10'h104] = 32'h8000_003C; mem[10'h105] = 32'h2000;
        mem[10'h200] = 32'h0;   mem[10'h201] = 32'h0046_3000;
        mem[10'h202] = 32'h8000_0046; mem[10'h203] = 32'h3000;
        kick(16'h100, 1'b0);
        repeat (4) @(negedge clk);
        start = 1'b1; head_addr = 16'h340;   // R12: ignored while busy
        @(negedge clk);
        start = 1'b0;
        settle();
        chk("R3 R12 frag count", nfr, 3);
        chk_frag("R3", 0, 32'h1000, 16'd40, 1'b0);
        chk_frag("R4", 1, 32'h2000, 16'd60, 1'b0);
        chk_frag("R7", 2, 32'h3000, 16'd70, 1'b0);
        chk("R6 wb first", mem[10'h101], 32'h0064_7000);
        chk("R6 wb second", mem[10'h201], 32'h0046_7000);
        chk("R6 frame_done", ndone, 2);
        chk("R7 chain_end", neoc, 1);
    endtask

    task automatic t_pad();
        clear_logs();
        mem[10'h300] = 32'h0; mem[10'h301] = 32'h0014_3000;
        mem[10'h302] = 32'h8000_0014; mem[10'h303] = 32'h4000;
        kick(16'h300, 1'b0);
        settle();
        chk("R10 frag count", nfr, 2);
        chk_frag("R10 data", 0, 32'h4000, 16'd20, 1'b0);
        chk_frag("R10 pad", 1, 32'h0, 16'd44, 1'b1);
        chk("R10 wb", mem[10'h301], 32'h0014_7000);
    endtask

    task automatic t_not_ready();
        clear_logs();
        mem[10'h340] = 32'h380; mem[10'h341] = 32'h0040_1000;
        kick(16'h340, 1'b0);
        settle();
        chk("R8 no frags", nfr, 0);
        chk("R8 no writes", nwr, 0);
        chk("R8 chain_end", neoc, 1);
        chk("R8 status kept", mem[10'h341], 32'h0040_1000);
    endtask

    task automatic t_single();
        clear_logs();
        mem[10'h380] = 32'h384; mem[10'h381] = 32'h0050_3000;
        mem[10'h382] = 32'h50;  mem[10'h383] = 32'h5000;
        mem[10'h384] = 32'h0;   mem[10'h385] = 32'h0048_3000;
        mem[10'h386] = 32'h48;  mem[10'h387] = 32'h6000;
        kick(16'h380, 1'b1);
        settle();
        chk("R5 frag count", nfr, 2);
        chk_frag("R5 first", 0, 32'h5000, 16'd80, 1'b0);
        chk_frag("R5 second", 1, 32'h6000, 16'd72, 1'b0);
        chk("R5 wb first", mem[10'h381], 32'h0050_7000);
        chk("R5 wb second", mem[10'h385], 32'h0048_7000);
    endtask

    task automatic t_ten();
        clear_logs();
        mem[10'h400] = 32'h0; mem[10'h401] = 32'h0064_3000;
        for (int i = 0; i < 10; i++) begin
            mem[10'h402 + 10'(2*i)] = 32'd10;
            mem[10'h403 + 10'(2*i)] = 32'h7000 + 32'(16*i);
        end
        mem[10'h416] = 32'd5; mem[10'h417] = 32'h9999;
        kick(16'h400, 1'b0);
        settle();
        chk("R4 max frags", nfr, 10);
        chk_frag("R4 tenth", 9, 32'h7090, 16'd10, 1'b0);
        chk("R4 wb", mem[10'h401], 32'h0064_7000);
    endtask

    task automatic t_eoc_bit();
        clear_logs();
        mem[10'h440] = 32'h460; mem[10'h441] = 32'h0040_3800;
        mem[10'h442] = 32'h8000_0040; mem[10'h443] = 32'h8000;
        mem[10'h460] = 32'h0; mem[10'h461] = 32'h0040_3000;
        mem[10'h462] = 32'h8000_0040; mem[10'h463] = 32'h8800;
        kick(16'h440, 1'b0);
        settle();
        chk("R9 frag count", nfr, 1);
        chk("R9 wb", mem[10'h441], 32'h0040_7800);
        chk("R9 chain_end", neoc, 1);
        chk("R9 next untouched", mem[10'h461], 32'h0040_3000);
    endtask

    task automatic t_stop();
        clear_logs();
        mem[10'h480] = 32'h4A0; mem[10'h481] = 32'h0050_3000;
        mem[10'h482] = 32'd40;  mem[10'h483] = 32'hA000;
        mem[10'h484] = 32'h8000_0028; mem[10'h485] = 32'hB000;
        mem[10'h4A0] = 32'h0;   mem[10'h4A1] = 32'h0050_3000;
        mem[10'h4A2] = 32'h8000_0050; mem[10'h4A3] = 32'hC000;
        kick(16'h480, 1'b0);
        repeat (3) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        settle();
        chk("R11 frag count", nfr, 2);
        chk("R11 wb current", mem[10'h481], 32'h0050_7000);
        chk("R11 writes", nwr, 1);
        chk("R11 no chain_end", neoc, 0);
        chk("R11 next untouched", mem[10'h4A1], 32'h0050_3000);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chain();
        t_pad();
        t_not_ready();
        t_single();
        t_ten();
        t_eoc_bit();
        t_stop();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule